// File: doc/BRIEF.md
# Parity Bus Transceiver with Error Latch

This block moves an 8-bit data word between two tristate ports, A and B. When it drives port B from port A, it also drives a parity pin. The parity bit is chosen so that the nine bits (data plus parity) hold an odd number of ones. When it drives port A from port B, it forwards the data unchanged. A checker watches the nine bits on port B at all times. If the count of ones on port B is even, the checker raises an error.

The error indication passes through a small latch before it reaches an active-low, open-drain style output. With `hold` low the latch is transparent. With `hold` high it keeps the value captured at the last clock edge on which it was transparent. An active-low clear overrides both and shows no error. Two active-low enables select the direction, isolation of both ports, or a diagnostic mode. In diagnostic mode the block drives port B from A with the parity bit inverted, which makes the checker report an error on purpose. Each pad is modelled as separate in, out and output-enable signals.

Top module: `parity_xcvr`

## Requirements
- R1: With `oeb_n`=0 and `oea_n`=1, `b_oe` and `par_oe` are 1 and `b_o` equals `a_i`. `par_o` is set so that `{b_o,par_o}` has an odd number of ones (for example `a_i`=8'h00 gives `par_o`=1).
- R2: With `oea_n`=0 and `oeb_n`=1, `a_oe` is 1 and `a_o` equals `b_i`. `b_oe` and `par_oe` are 0.
- R3: The checker reports an error when the nine bits `{b_i,par_i}` hold an even number of ones. This applies in every mode, and any single-bit error in an odd word is therefore detected.
- R4: With `oea_n`=1 and `oeb_n`=1, none of `a_oe`, `b_oe` and `par_oe` is set.
- R5: With `oea_n`=0 and `oeb_n`=0, the block drives B from A with `par_o` inverted, so `{b_o,par_o}` holds an even number of ones. Seen back on port B, this word raises the error.
- R6: `err_o` is always 0. An error is shown by `err_oe`=1, which pulls the line low. `err_oe`=0 releases the line and means no error.
- R7: With `hold`=0 and `clr_n`=1, `err_oe` follows the checker in the same cycle, and the stored flag takes the checker value at each rising `clk` edge.
- R8: With `hold`=1 and `clr_n`=1, `err_oe` shows the stored flag and does not change while `{b_i,par_i}` changes.
- R9: With `clr_n`=0, `err_oe` is 0 at once and the stored flag is cleared at the next rising edge. This takes priority over `hold`.
- R10: An active-low `rst_n` clears the stored flag.
- R11: `a_oe` and `b_oe` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the error flag store |
| rst_n | input | 1 | Asynchronous active-low reset |
| oea_n | input | 1 | Active-low enable for driving port A |
| oeb_n | input | 1 | Active-low enable for driving port B and the parity pin |
| hold | input | 1 | 0: transparent error latch; 1: hold the stored flag |
| clr_n | input | 1 | Active-low clear of the error flag |
| a_i | input | 8 | Port A pad input |
| a_o | output | 8 | Port A pad output |
| a_oe | output | 1 | Port A output enable |
| b_i | input | 8 | Port B pad input |
| b_o | output | 8 | Port B pad output |
| b_oe | output | 1 | Port B output enable |
| par_i | input | 1 | Parity pad input |
| par_o | output | 1 | Parity pad output |
| par_oe | output | 1 | Parity pad output enable |
| err_o | output | 1 | Error pad output value, always 0 |
| err_oe | output | 1 | Error pad enable; 1 pulls low to signal an error |

## Verification
The assertions assume that the external bus is resolved correctly. When the block enables port B or the parity pin, `b_i` and `par_i` must carry what the block drives, as a real shared pad would. The hold assertion also assumes that `hold` and `clr_n` change only between clock edges. The bench meets both conditions with a bus model that loops `b_o` and `par_o` back whenever their enables are set. It changes every control input half a period away from the rising edge.

// File: rtl/parity_xcvr.sv
module parity_xcvr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oea_n,
  input  logic         oeb_n,
  input  logic         hold,
  input  logic         clr_n,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic         a_oe,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic         b_oe,
  input  logic         par_i,
  output logic         par_o,
  output logic         par_oe,
  output logic         err_o,
  output logic         err_oe
);

  logic to_b, to_a, force_bad;
  logic live_err, stored_err;

  assign to_b      = !oeb_n;
  assign to_a      = !oea_n && oeb_n;
  assign force_bad = !oea_n && !oeb_n;

  assign b_o    = a_i;
  assign b_oe   = to_b;
  assign par_oe = to_b;
  assign par_o  = force_bad ? (^a_i) : ~(^a_i);

  assign a_o  = b_i;
  assign a_oe = to_a;

  assign live_err = ~(^{b_i, par_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stored_err <= 1'b0;
    else if (!clr_n)  stored_err <= 1'b0;
    else if (!hold)   stored_err <= live_err;
  end

  assign err_o  = 1'b0;
  assign err_oe = clr_n && (hold ? stored_err : live_err);

  AST_ODD_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!oeb_n && oea_n) |-> (^{b_o, par_o}) == 1'b1); // R1
  AST_A_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (!oea_n && oeb_n) |-> (a_oe && a_o == b_i && !b_oe)); // R2
  AST_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
    (oea_n && oeb_n) |-> !(a_oe || b_oe || par_oe)); // R4
  AST_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (!oea_n && !oeb_n) |-> (^{b_o, par_o}) == 1'b0); // R5
  AST_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    err_o == 1'b0); // R6
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && clr_n && $past(hold && clr_n)) |-> $stable(err_oe)); // R8
  AST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> !err_oe); // R9
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_oe && b_oe)); // R11

endmodule

// File: tb/parity_xcvr_tb_top.sv
module parity_xcvr_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic oea_n = 1, oeb_n = 1, hold = 0, clr_n = 1;
  logic [7:0] a_i = 0, b_ext = 0;
  logic p_ext = 0;
  logic [7:0] a_o, b_o, b_bus;
  logic a_oe, b_oe, par_o, par_oe, err_o, err_oe, p_bus;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  assign b_bus = b_oe ? b_o : b_ext;
  assign p_bus = par_oe ? par_o : p_ext;

  parity_xcvr #(.W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .oea_n(oea_n), .oeb_n(oeb_n),
    .hold(hold), .clr_n(clr_n),
    .a_i(a_i), .a_o(a_o), .a_oe(a_oe),
    .b_i(b_bus), .b_o(b_o), .b_oe(b_oe),
    .par_i(p_bus), .par_o(par_o), .par_oe(par_oe),
    .err_o(err_o), .err_oe(err_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // {oea_n, oeb_n, a, b_ext, p_ext, exp_a_oe, exp_b_oe, exp_par, exp_err}
  localparam logic [22:0] VEC [8] = '{
    {1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'h01, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {1'b0, 1'b1, 8'h00, 8'h55, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h00, 8'h55, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {1'b0, 1'b1, 8'h00, 8'h80, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {1'b1, 1'b1, 8'h00, 8'h03, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    hold = 1;
    #12 rst_n = 1;
    @(negedge clk);
    chk("R10 reset flag clear", err_oe, 0);
    chk("R6 err_o low", err_o, 0);
    hold = 0;

    for (int i = 0; i < 8; i++) begin
      {oea_n, oeb_n, a_i, b_ext, p_ext} = VEC[i][22:4];
      #1;
      chk("R11/R2/R4 a_oe", a_oe, VEC[i][3]);
      chk("R1/R4/R5 b_oe", b_oe, VEC[i][2]);
      if (VEC[i][2]) begin
        chk("R1/R5 par_o", par_o, VEC[i][1]);
        chk("R1 b_o equals a_i", b_o, a_i);
      end
      if (VEC[i][3]) chk("R2 a_o equals b_i", a_o, b_ext);
      chk("R3/R7 err_oe", err_oe, VEC[i][0]);
      @(negedge clk);
    end

    oea_n = 1; oeb_n = 0;
    for (int i = 0; i < 40; i++) begin
      a_i = 8'($urandom);
      #1;
      chk("R1 odd parity random", ^{b_o, par_o}, 1);
      chk("R1 b_o random", b_o, a_i);
      @(negedge clk);
    end

    oea_n = 0; oeb_n = 1;
    for (int i = 0; i < 40; i++) begin
      logic [8:0] w;
      int k;
      b_ext = 8'($urandom);
      p_ext = ~(^b_ext);
      #1;
      chk("R3 good word no error", err_oe, 0);
      k = $urandom_range(0, 8);
      w = {b_ext, p_ext} ^ (9'd1 << k);
      {b_ext, p_ext} = w;
      #1;
      chk("R3 single-bit error", err_oe, 1);
      @(negedge clk);
    end

    // latch hold: capture error, then hold while input becomes good
    b_ext = 8'h01; p_ext = 1'b1;
    @(negedge clk);
    hold = 1;
    b_ext = 8'h01; p_ext = 1'b0;
    #1;
    chk("R8 hold keeps error", err_oe, 1);
    @(negedge clk);
    chk("R8 hold after edge", err_oe, 1);
    hold = 0;
    #1;
    chk("R7 transparent again", err_oe, 0);
    @(negedge clk);

    // clear has priority over hold
    p_ext = 1'b1;
    @(negedge clk);
    hold = 1; clr_n = 0;
    #1;
    chk("R9 clear immediate", err_oe, 0);
    @(negedge clk);
    clr_n = 1;
    #1;
    chk("R9 cleared flag held", err_oe, 0);
    @(negedge clk);
    hold = 0;
    #1;
    chk("R7 live error after clear", err_oe, 1);

    // forced diagnostic with random data
    oea_n = 0; oeb_n = 0;
    for (int i = 0; i < 10; i++) begin
      a_i = 8'($urandom);
      #1;
      chk("R5 forced even word", ^{b_o, par_o}, 0);
      chk("R5 forced error seen", err_oe, 1);
      chk("R11 no contention", a_oe & b_oe, 0);
      @(negedge clk);
    end

    // reset clears stored flag while holding
    hold = 1;
    rst_n = 0;
    #1;
    chk("R10 reset under hold", err_oe, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 stays clear", err_oe, 0);
    chk("R6 err_o never high", err_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule